// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM's contents alive and brings the device up after power-on. Out of reset it holds the memory bus, waits out a long power-up pause, then runs a fixed number of CAS-before-RAS refresh cycles before it declares the memory ready. From then on an interval timer raises one refresh obligation per refresh period. Obligations are collected in a backlog counter. The device's own internal counter picks the row, so the block never drives an address.

The access controller shares the strobes with this block through a level request and grant. The controller raises `acc_req` and keeps it high for the whole of one access. `acc_gnt` stays high until the request drops. When the request is low and a refresh is owed, the block takes the bus and performs one CAS-before-RAS cycle, driving RAS, CAS and WE itself. Access requests may postpone refreshes until the backlog reaches a limit. From then on a refresh goes ahead of any new access. An access already in progress is never cut short. Every interval and count is a parameter expressed in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and after reset `ras_n`, `cas_n` and `we_n` are 1, `mem_ready` and `acc_gnt` are 0 and `bus_own` is 1; a reset applied mid-run returns the block to this state.
- R2: After reset is released, `cas_n` and `ras_n` stay high for at least PAUSE_CYC cycles.
- R3: After the pause, exactly INIT_REFS refresh cycles complete before `mem_ready` rises, and `acc_gnt` is never 1 while `mem_ready` is 0.
- R4: In every refresh cycle, `cas_n` is low for at least CAS_LEAD_CYC cycles before `ras_n` falls and stays low for as long as `ras_n` is low; `we_n` is held at 1 at all times.
- R5: `ras_n` stays low for exactly RAS_LOW_CYC cycles per refresh. Before each `cas_n` fall both strobes have been high for at least PRE_CYC cycles, and before each `ras_n` fall `ras_n` has been high for at least PRE_CYC+CAS_LEAD_CYC cycles.
- R6: Once `mem_ready` is 1, one refresh becomes owed every REFI_CYC cycles. With the bus otherwise idle, each one is carried out, so after the backlog drains the refreshes completed since ready equal the whole periods elapsed.
- R7: An owed refresh starts when no access is requested. While fewer than MAX_POSTPONE refreshes are owed, a request that is present when the block is free is granted first and the refresh is deferred.
- R8: Once MAX_POSTPONE or more refreshes are owed, a refresh is performed before any new access. A granted access keeps `acc_gnt` high until `acc_req` drops, however many refreshes become owed meanwhile.
- R9: `acc_gnt` and `bus_own` are never 1 together, and whenever `bus_own` is 0 the block holds `ras_n` and `cas_n` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_req | input | 1 | Access controller requests the bus; held for one whole access |
| acc_gnt | output | 1 | Access controller owns the strobes; stays high while `acc_req` is high |
| bus_own | output | 1 | This block owns the strobes (power-up or refresh) |
| mem_ready | output | 1 | Power-up sequence complete; normal traffic allowed |
| ras_n | output | 1 | Row strobe, active low, driven while `bus_own` is high |
| cas_n | output | 1 | Column strobe, active low, driven while `bus_own` is high |
| we_n | output | 1 | Write enable, active low, held inactive |

## Verification
A wrong phase in the strobe sequencer shows at the ports within one refresh cycle. The symptom is a RAS fall without CAS already low, a RAS low time other than RAS_LOW_CYC, or a shortened precharge. A wrong state in the interval timer or the backlog counter changes how many refreshes complete. Once traffic stops it shows up within one refresh period as a mismatch between completed refresh cycles and elapsed periods. Arbitration errors show at the next access as a grant during a refresh, a refresh taken under an unfinished access, or a refresh that never arrives under dense traffic.

// File: rtl/dram_ref_pkg.sv
// Shared types for the DRAM refresh scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package dram_ref_pkg;

    // Scheduler ownership states.
    typedef enum logic [2:0] {
        TOP_PAUSE,  // power-up wait, bus held
        TOP_INIT,   // initialization refresh cycles
        TOP_IDLE,   // bus free, deciding
        TOP_ACC,    // access controller granted
        TOP_REF     // periodic refresh in progress
    } top_state_t;

    // Phases of one CAS-before-RAS cycle.
    typedef enum logic [1:0] {
        SQ_IDLE,    // strobes high, waiting for go
        SQ_PRE,     // both strobes high (precharge)
        SQ_CASLO,   // CAS low, RAS high (CAS lead)
        SQ_RASLO    // both low (refresh active)
    } seq_phase_t;

endpackage

// File: rtl/ref_interval_timer.sv
// Refresh interval timer.
// Emits a one-cycle tick once every PERIOD_CYC cycles while run is high;
// the count restarts whenever run is low.
// Assumes: PERIOD_CYC >= 2.
module ref_interval_timer #(
    parameter int PERIOD_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(PERIOD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt;

    // Counts cycles of run, wrapping at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // Ticks are isolated single-cycle pulses.
    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("interval tick lasted more than one cycle");

endmodule

// File: rtl/ref_backlog.sv
// Counter of owed refreshes.
// Adds one on each interval tick and removes one per completed refresh.
// pending: at least one owed; urgent: the postponement limit is reached.
// Saturates at the counter's all-ones value.
// Assumes: clr holds it at zero until the memory is ready.
module ref_backlog #(
    parameter int MAX_POSTPONE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic pending,
    output logic urgent
);
    localparam int BW = $clog2(2 * MAX_POSTPONE + 2);
    localparam logic [BW-1:0] LIMIT = BW'(MAX_POSTPONE);
    localparam logic [BW-1:0] FULL  = {BW{1'b1}};

    logic [BW-1:0] owed;

    // Tracks the net number of refreshes owed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            owed <= '0;
        end else if (inc && !dec && owed != FULL) begin
            owed <= owed + 1'b1;
        end else if (dec && !inc && owed != '0) begin
            owed <= owed - 1'b1;
        end
    end

    assign pending = (owed != '0);
    assign urgent  = (owed >= LIMIT);

    // The count moves by at most one per cycle.
    p_owed_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (owed != $past(owed)) |->
            (owed == $past(owed) + 1'b1 || owed == $past(owed) - 1'b1 || owed == '0))
        else $error("backlog count jumped");

endmodule

// File: rtl/cbr_sequencer.sv
// One CAS-before-RAS refresh cycle per go pulse.
// Precharge (both strobes high), then CAS low alone, then both low.
// Strobes are registered from the next phase, so they change cleanly on
// clock edges. done is high in the last cycle with RAS low.
// Assumes: all phase lengths >= 1; go is only honoured while idle.
module cbr_sequencer import dram_ref_pkg::*; #(
    parameter int PRE_CYC      = 2,
    parameter int CAS_LEAD_CYC = 1,
    parameter int RAS_LOW_CYC  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic idle,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int MAXLEN = (PRE_CYC > CAS_LEAD_CYC)
        ? ((PRE_CYC > RAS_LOW_CYC) ? PRE_CYC : RAS_LOW_CYC)
        : ((CAS_LEAD_CYC > RAS_LOW_CYC) ? CAS_LEAD_CYC : RAS_LOW_CYC);
    localparam int CW = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] CAS_LAST = CW'(CAS_LEAD_CYC - 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(RAS_LOW_CYC - 1);

    seq_phase_t    ph, ph_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // Chooses the next phase and the cycle count within it.
    always_comb begin
        ph_nxt  = ph;
        cnt_nxt = cnt + 1'b1;
        case (ph)
            SQ_IDLE: begin
                cnt_nxt = '0;
                if (go) ph_nxt = SQ_PRE;
            end
            SQ_PRE: begin
                if (cnt == PRE_LAST) begin
                    ph_nxt  = SQ_CASLO;
                    cnt_nxt = '0;
                end
            end
            SQ_CASLO: begin
                if (cnt == CAS_LAST) begin
                    ph_nxt  = SQ_RASLO;
                    cnt_nxt = '0;
                end
            end
            SQ_RASLO: begin
                if (cnt == RAS_LAST) begin
                    ph_nxt  = SQ_IDLE;
                    cnt_nxt = '0;
                end
            end
            default: begin
                ph_nxt  = SQ_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    // Holds phase and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            ph  <= ph_nxt;
            cnt <= cnt_nxt;
        end
    end

    // Registers the strobes from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
        end else begin
            ras_n <= (ph_nxt != SQ_RASLO);
            cas_n <= !(ph_nxt == SQ_CASLO || ph_nxt == SQ_RASLO);
        end
    end

    assign idle = (ph == SQ_IDLE);
    assign done = (ph == SQ_RASLO) && (cnt == RAS_LAST);

    // RAS is only low while CAS is low.
    p_ras_under_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n)
        else $error("RAS low without CAS low");

    // CAS was already low in the cycle before RAS fell.
    p_cas_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n))
        else $error("RAS fell without CAS leading");

endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM refresh and power-up scheduler (top).
// Out of reset: holds the bus for PAUSE_CYC cycles, then runs INIT_REFS
// CAS-before-RAS cycles and raises mem_ready. Afterwards it arbitrates
// between owed refreshes and the access controller's level request.
// Assumes: acc_req stays high for the whole of one access; the access
// controller drives the strobes only while acc_gnt is high.
module dram_refresh_sched import dram_ref_pkg::*; #(
    parameter int PAUSE_CYC    = 10000,
    parameter int INIT_REFS    = 8,
    parameter int REFI_CYC     = 780,
    parameter int MAX_POSTPONE = 8,
    parameter int PRE_CYC      = 2,
    parameter int CAS_LEAD_CYC = 1,
    parameter int RAS_LOW_CYC  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req,
    output logic acc_gnt,
    output logic bus_own,
    output logic mem_ready,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int IW = $clog2(INIT_REFS + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [IW-1:0] INIT_DONE  = IW'(INIT_REFS);

    top_state_t    st, st_nxt;
    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_cnt;
    logic          seq_go, seq_idle, seq_done;
    logic          tick, pending, urgent, take;

    ref_interval_timer #(.PERIOD_CYC(REFI_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (mem_ready),
        .tick (tick)
    );

    ref_backlog #(.MAX_POSTPONE(MAX_POSTPONE)) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!mem_ready),
        .inc    (tick),
        .dec    (seq_done && st == TOP_REF),
        .pending(pending),
        .urgent (urgent)
    );

    cbr_sequencer #(
        .PRE_CYC     (PRE_CYC),
        .CAS_LEAD_CYC(CAS_LEAD_CYC),
        .RAS_LOW_CYC (RAS_LOW_CYC)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (seq_go),
        .idle (seq_idle),
        .done (seq_done),
        .ras_n(ras_n),
        .cas_n(cas_n)
    );

    // A refresh is taken when owed and either no access waits or the limit is hit.
    assign take = pending && (!acc_req || urgent);

    // Ownership state machine and sequencer launch.
    always_comb begin
        st_nxt = st;
        seq_go = 1'b0;
        case (st)
            TOP_PAUSE: begin
                if (pause_cnt == PAUSE_LAST) st_nxt = TOP_INIT;
            end
            TOP_INIT: begin
                if (seq_idle) begin
                    if (init_cnt == INIT_DONE) st_nxt = TOP_IDLE;
                    else                       seq_go = 1'b1;
                end
            end
            TOP_IDLE: begin
                if (take) begin
                    seq_go = 1'b1;
                    st_nxt = TOP_REF;
                end else if (acc_req) begin
                    st_nxt = TOP_ACC;
                end
            end
            TOP_ACC: begin
                if (!acc_req) st_nxt = TOP_IDLE;
            end
            TOP_REF: begin
                if (seq_done) st_nxt = TOP_IDLE;
            end
            default: st_nxt = TOP_PAUSE;
        endcase
    end

    // Holds the ownership state.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= TOP_PAUSE;
        else        st <= st_nxt;
    end

    // Counts the power-up pause.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         pause_cnt <= '0;
        else if (st == TOP_PAUSE && pause_cnt != PAUSE_LAST) pause_cnt <= pause_cnt + 1'b1;
    end

    // Counts completed initialization refresh cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                        init_cnt <= '0;
        else if (st == TOP_INIT && seq_done) init_cnt <= init_cnt + 1'b1;
    end

    // Registers readiness from the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_ready <= 1'b0;
        else        mem_ready <= (st_nxt != TOP_PAUSE) && (st_nxt != TOP_INIT);
    end

    assign acc_gnt = (st == TOP_ACC);
    assign bus_own = (st == TOP_PAUSE) || (st == TOP_INIT) || (st == TOP_REF);
    assign we_n    = 1'b1;

    // The two owners never hold the bus together.
    p_gnt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_gnt && bus_own))
        else $error("grant while block owns bus");

    // Strobes are released whenever the block does not own the bus.
    p_idle_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (ras_n && cas_n))
        else $error("strobe driven without ownership");

    // No grant before initialization finishes.
    p_gnt_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> mem_ready)
        else $error("grant before ready");

    // A granted access is not interrupted while its request stays high.
    p_gnt_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_gnt && acc_req) |=> acc_gnt)
        else $error("access interrupted");

    // Readiness never drops outside reset.
    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |=> mem_ready)
        else $error("ready dropped");

endmodule

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
    localparam int PAUSE = 50;
    localparam int NINIT = 8;
    localparam int REFI  = 60;
    localparam int MAXP  = 4;
    localparam int PRE   = 2;
    localparam int CLEAD = 1;
    localparam int RLOW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_req = 1'b0;
    logic acc_gnt, bus_own, mem_ready, ras_n, cas_n, we_n;

    always #10 clk = ~clk;   // 50 MHz

    dram_refresh_sched #(
        .PAUSE_CYC(PAUSE), .INIT_REFS(NINIT), .REFI_CYC(REFI),
        .MAX_POSTPONE(MAXP), .PRE_CYC(PRE), .CAS_LEAD_CYC(CLEAD),
        .RAS_LOW_CYC(RLOW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_gnt(acc_gnt),
        .bus_own(bus_own), .mem_ready(mem_ready), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor state (updated at negedge).
    int  since_rst, first_cas, rdy_cyc;
    int  rises_init, rises_rdy, rises_win;
    int  ras_run, cas_run;
    logic ras_q, cas_q;
    bit  in_win;

    always @(negedge clk) begin
        if (!rst_n) begin
            since_rst = 0; first_cas = -1; rdy_cyc = 0;
            rises_init = 0; rises_rdy = 0; rises_win = 0;
            ras_run = 0; cas_run = 0; ras_q = 1'b1; cas_q = 1'b1;
        end else begin
            since_rst++;
            if (mem_ready) rdy_cyc++;
            if (acc_gnt && bus_own) chk(0, "R9", "grant with bus_own", 1, 0);
            if (!bus_own && (!ras_n || !cas_n)) chk(0, "R9", "strobe low without ownership", 0, 1);
            if (acc_gnt && !mem_ready) chk(0, "R3", "grant before ready", 1, 0);
            if (!we_n) chk(0, "R4", "we_n driven low", 0, 1);
            if (!ras_n && cas_n) chk(0, "R4", "RAS low with CAS high", 1, 0);
            if (!cas_n && first_cas < 0) first_cas = since_rst;
            if (ras_q && !ras_n) begin
                chk(!cas_n && cas_q == 1'b0 && cas_run >= CLEAD, "R4", "CAS lead cycles", cas_run, CLEAD);
                chk(ras_run >= PRE + CLEAD, "R5", "RAS high before fall", ras_run, PRE + CLEAD);
                chk(we_n, "R4", "we_n at RAS fall", we_n, 1);
            end
            if (!ras_q && ras_n) begin
                chk(ras_run == RLOW, "R5", "RAS low length", ras_run, RLOW);
                if (mem_ready) begin
                    rises_rdy++;
                    if (in_win) rises_win++;
                end else begin
                    rises_init++;
                end
            end
            if (cas_q && !cas_n)
                chk(cas_run >= PRE, "R5", "CAS high before fall", cas_run, PRE);
            ras_run = (ras_n == ras_q) ? ras_run + 1 : 1;
            cas_run = (cas_n == cas_q) ? cas_run + 1 : 1;
            ras_q = ras_n;
            cas_q = cas_n;
        end
    end

    task automatic step(input int k);
        repeat (k) @(negedge clk);
        #2;
    endtask

    // One access: raise, wait for grant, hold len cycles in total, drop.
    task automatic do_access(input int len);
        int w;
        acc_req = 1'b1;
        w = 0;
        do begin
            step(1);
            w++;
        end while (!acc_gnt && w < 300);
        chk(acc_gnt, "R8", "grant arrives", acc_gnt, 1);
        if (len > 1) step(len - 1);
        acc_req = 1'b0;
    endtask

    // Waits for traffic to drain, then aligns inside a refresh period.
    task automatic settle();
        step(REFI + 40);
        while (((rdy_cyc - 1) % REFI) != REFI - 2) step(1);
    endtask

    typedef struct packed {
        int n_acc;
        int len;
        int gap;
        int min_r;
        int max_r;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{10,   8, 1, 0, 0},  // R7: dense requests below limit defer refresh
        '{30,   6, 3, 3, 6},  // R7: gaps let owed refreshes run
        '{1,  320, 1, 0, 0},  // R8: long access never interrupted
        '{40,   8, 1, 1, 7}   // R8: at the limit refresh precedes new access
    };

    initial begin
        // R1: reset state
        step(3);
        chk(ras_n && cas_n && we_n, "R1", "strobes high in reset", {ras_n, cas_n, we_n}, 7);
        chk(!mem_ready, "R1", "ready low in reset", mem_ready, 0);
        chk(!acc_gnt, "R1", "grant low in reset", acc_gnt, 0);
        chk(bus_own, "R1", "bus_own in reset", bus_own, 1);

        // R2/R3: power-up with a request pending throughout
        acc_req = 1'b1;
        rst_n = 1'b1;
        begin
            int w = 0;
            while (!mem_ready && w < 2000) begin step(1); w++; end
        end
        chk(first_cas >= PAUSE && first_cas <= PAUSE + PRE + 4, "R2",
            "cycles to first CAS fall", first_cas, PAUSE);
        chk(rises_init == NINIT, "R3", "init refresh count", rises_init, NINIT);
        chk(mem_ready, "R3", "ready after init", mem_ready, 1);
        step(2);
        chk(acc_gnt, "R3", "grant once ready", acc_gnt, 1);
        acc_req = 1'b0;

        // R6: idle refresh cadence
        settle();
        chk(rises_rdy == (rdy_cyc - 1) / REFI, "R6", "refreshes vs periods (idle)",
            rises_rdy, (rdy_cyc - 1) / REFI);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            rises_win = 0;
            in_win = 1'b1;
            for (int a = 0; a < VECS[v].n_acc; a++) begin
                do_access(VECS[v].len);
                if (a != VECS[v].n_acc - 1) step(VECS[v].gap);
            end
            in_win = 1'b0;
            chk(rises_win >= VECS[v].min_r && rises_win <= VECS[v].max_r,
                (v < 2) ? "R7" : "R8", "refreshes during traffic", rises_win, VECS[v].min_r);
            settle();
            chk(rises_rdy == (rdy_cyc - 1) / REFI, "R6", "refreshes vs periods after traffic",
                rises_rdy, (rdy_cyc - 1) / REFI);
        end

        // R1: mid-run reset
        acc_req = 1'b1;
        step(4);
        rst_n = 1'b0;
        step(2);
        chk(!mem_ready && !acc_gnt && bus_own, "R1", "state after mid-run reset",
            {mem_ready, acc_gnt, bus_own}, 1);
        chk(ras_n && cas_n, "R1", "strobes after mid-run reset", {ras_n, cas_n}, 3);
        rst_n = 1'b1;
        step(PAUSE / 2);
        chk(!acc_gnt && ras_n && cas_n, "R2", "quiet during second pause",
            {acc_gnt, ras_n, cas_n}, 3);
        acc_req = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule